// File: doc/BRIEF.md
# Break interrupt entry sequencer

This block sits between an address comparator and the instruction sequencer of a small 8-bit CPU. When the comparator reports a match, the block waits for the running instruction to finish. It then forces the software-interrupt opcode into the instruction register and loads the program counter with the break vector. There is one vector for normal operation and another for monitor mode.

A match that comes in the middle of an instruction is held until that instruction's last cycle. A match that comes on the last cycle is taken in the very next cycle. While the break is active, a return-from-interrupt ends it only if the break request has already been withdrawn. If the request is still up, the break stays active.

Top module: `brk_entry_seq`

## Requirements
- R1: When `match_i` and `insn_last_i` are both high and no break is active, `ir_load_o` and `pc_load_o` are high together in the next cycle, for exactly one cycle.
- R2: `ir_val_o` is 8'h83 (the software-interrupt opcode) while `ir_load_o` is high, and 8'h00 otherwise.
- R3: `pc_val_o` is 16'hFFFC if `monitor_i` was low in the cycle the break was taken, and 16'hFEFC if it was high. It is 16'h0000 when `pc_load_o` is low.
- R4: A match pulse seen while `insn_last_i` is low is latched. The load happens in the cycle after the next cycle in which `insn_last_i` is high, even if the match lasted only one cycle.
- R5: While a match is pending and `insn_last_i` stays low, no load is issued.
- R6: `brk_active_o` rises in the same cycle as the load and stays high until the break is exited.
- R7: `rti_done_i` high together with `req_clear_i` high while a break is active clears `brk_active_o` in the next cycle. In that same cycle `brk_exit_o` is high, for one cycle only.
- R8: `rti_done_i` high while `req_clear_i` is low leaves `brk_active_o` high and gives no `brk_exit_o` pulse.
- R9: A match while a break is active is ignored. It causes no load, and no load follows after the break is exited.
- R10: While `rst_ni` is low, all outputs are zero and any pending match is discarded.
- R11: `rti_done_i` while no break is active does not pulse `brk_exit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_i | input | 1 | Break address match from the comparator |
| insn_last_i | input | 1 | Last cycle of the current instruction |
| monitor_i | input | 1 | Monitor mode selects the alternate vector |
| rti_done_i | input | 1 | Return-from-interrupt executed |
| req_clear_i | input | 1 | Break request has been withdrawn |
| ir_load_o | output | 1 | Instruction register load strobe |
| ir_val_o | output | 8 | Opcode forced into the instruction register |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_val_o | output | 16 | Vector address, high byte in [15:8] |
| brk_active_o | output | 1 | A break is in progress |
| brk_exit_o | output | 1 | One-cycle pulse when the break ends |

## Verification
The bench sends a one-cycle match in the middle of an instruction. A design without the pending latch would lose that match and never load. A last-cycle match is checked in the very next cycle, so an extra pipeline stage shows up as a late strobe. Each of the two vectors is checked against the monitor level sampled at take time, which catches a swapped or late-sampled selection. The RTI tests are run with the request both held and cleared, and a match is also sent during an active break. Together these expose an exit that ignores the request status, and a match re-entered or left pending after the break ends.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned ADDR_W = 16;
  localparam logic [OP_W-1:0]   SWI_OPCODE  = 8'h83;
  localparam logic [ADDR_W-1:0] VEC_NORMAL  = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_MONITOR = 16'hFEFC;
endpackage

// File: rtl/brk_pend.sv
module brk_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic active_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            pend_q <= 1'b0;
    else if (take_i)                        pend_q <= 1'b0;
    else if (match_i && !active_i)          pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/brk_inject.sv
module brk_inject #(
  parameter int unsigned          OP_W    = 8,
  parameter int unsigned          ADDR_W  = 16,
  parameter logic [OP_W-1:0]      OPCODE  = 8'h83,
  parameter logic [ADDR_W-1:0]    VEC_NRM = 16'hFFFC,
  parameter logic [ADDR_W-1:0]    VEC_MON = 16'hFEFC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              monitor_i,
  output logic              ir_load_o,
  output logic [OP_W-1:0]   ir_val_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_val_o
);
  logic              load_q;
  logic [ADDR_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      load_q <= take_i;
      vec_q  <= take_i ? (monitor_i ? VEC_MON : VEC_NRM) : '0;
    end
  end

  assign ir_load_o = load_q;
  assign pc_load_o = load_q;
  assign ir_val_o  = load_q ? OPCODE : '0;
  assign pc_val_o  = vec_q;
endmodule

// File: rtl/brk_track.sv
module brk_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic rti_done_i,
  input  logic req_clear_i,
  output logic active_o,
  output logic exit_o
);
  logic active_q, exit_q, leave;

  assign leave = active_q && rti_done_i && req_clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      exit_q   <= 1'b0;
    end else begin
      exit_q <= leave;
      if (take_i)     active_q <= 1'b1;
      else if (leave) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign exit_o   = exit_q;
endmodule

// File: rtl/brk_entry_seq.sv
module brk_entry_seq
  import brk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              match_i,
  input  logic              insn_last_i,
  input  logic              monitor_i,
  input  logic              rti_done_i,
  input  logic              req_clear_i,
  output logic              ir_load_o,
  output logic [OP_W-1:0]   ir_val_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_val_o,
  output logic              brk_active_o,
  output logic              brk_exit_o
);
  logic pend, active, take;

  // take on the boundary; same-cycle match bypasses the latch
  assign take = (pend || match_i) && insn_last_i && !active;

  brk_pend u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_i  (match_i),
    .active_i (active),
    .take_i   (take),
    .pend_o   (pend)
  );

  brk_inject #(
    .OP_W    (OP_W),
    .ADDR_W  (ADDR_W),
    .OPCODE  (SWI_OPCODE),
    .VEC_NRM (VEC_NORMAL),
    .VEC_MON (VEC_MONITOR)
  ) u_inject (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .monitor_i (monitor_i),
    .ir_load_o (ir_load_o),
    .ir_val_o  (ir_val_o),
    .pc_load_o (pc_load_o),
    .pc_val_o  (pc_val_o)
  );

  brk_track u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .rti_done_i  (rti_done_i),
    .req_clear_i (req_clear_i),
    .active_o    (active),
    .exit_o      (brk_exit_o)
  );

  assign brk_active_o = active;
endmodule

// File: rtl/brk_entry_seq_chk.sv
module brk_entry_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        match_i,
  input logic        insn_last_i,
  input logic        monitor_i,
  input logic        rti_done_i,
  input logic        req_clear_i,
  input logic        ir_load_o,
  input logic [7:0]  ir_val_o,
  input logic        pc_load_o,
  input logic [15:0] pc_val_o,
  input logic        brk_active_o,
  input logic        brk_exit_o
);
  a_r1_last_match_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && insn_last_i && !brk_active_o) |=> (ir_load_o && pc_load_o));

  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_load_o |=> !ir_load_o);

  a_r2_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_load_o |-> ir_val_o == 8'h83);

  a_r3_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> pc_val_o == ($past(monitor_i) ? 16'hFEFC : 16'hFFFC));

  a_r6_active_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_load_o |-> brk_active_o);

  a_r8_no_exit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_active_o && rti_done_i && !req_clear_i) |=> (brk_active_o && !brk_exit_o));

  a_r7_exit_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_exit_o |-> ($past(rti_done_i && req_clear_i && brk_active_o) && !brk_active_o));
endmodule

bind brk_entry_seq brk_entry_seq_chk u_chk (.*);

// File: tb/brk_entry_seq_tb.sv
module brk_entry_seq_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic match_i = 0, insn_last_i = 0, monitor_i = 0, rti_done_i = 0, req_clear_i = 0;
  logic ir_load_o, pc_load_o, brk_active_o, brk_exit_o;
  logic [7:0]  ir_val_o;
  logic [15:0] pc_val_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  brk_entry_seq u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic m, logic l, logic mon, logic rti, logic clr);
    @(negedge clk_i);
    match_i = m; insn_last_i = l; monitor_i = mon; rti_done_i = rti; req_clear_i = clr;
  endtask

  // apply inputs for one edge, then clear and look at the result
  task automatic cyc(logic m, logic l, logic mon, logic rti, logic clr);
    drive(m, l, mon, rti, clr);
    drive(0, 0, mon, 0, clr);
  endtask

  task automatic do_exit();
    cyc(0, 0, 0, 1, 1);
    chk("R7 exit pulse", brk_exit_o, 1);
    chk("R7 active cleared", brk_active_o, 0);
    drive(0, 0, 0, 0, 0);
    chk("R7 exit one cycle", brk_exit_o, 0);
  endtask

  task automatic t_reset();
    rst_ni = 0;
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    chk("R10 ir_load", ir_load_o, 0);
    chk("R10 pc_val", pc_val_o, 0);
    chk("R10 active", brk_active_o, 0);
    rst_ni = 1;
    cyc(0, 1, 0, 0, 0);
    chk("R10 pending discarded", ir_load_o, 0);
  endtask

  task automatic t_last_normal();
    cyc(1, 1, 0, 0, 0);
    chk("R1 ir_load", ir_load_o, 1);
    chk("R1 pc_load", pc_load_o, 1);
    chk("R2 opcode", ir_val_o, 8'h83);
    chk("R3 normal vector", pc_val_o, 16'hFFFC);
    chk("R6 active on load", brk_active_o, 1);
    drive(0, 0, 0, 0, 0);
    chk("R1 one cycle", ir_load_o, 0);
    chk("R2 idle opcode", ir_val_o, 0);
    chk("R3 idle vector", pc_val_o, 0);
    chk("R6 active holds", brk_active_o, 1);
    do_exit();
  endtask

  task automatic t_mid_monitor();
    cyc(1, 0, 1, 0, 0);
    chk("R5 no load mid", ir_load_o, 0);
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0);
    chk("R5 still waiting", ir_load_o, 0);
    chk("R5 not active", brk_active_o, 0);
    cyc(0, 1, 1, 0, 0);
    chk("R4 pending taken", ir_load_o, 1);
    chk("R3 monitor vector", pc_val_o, 16'hFEFC);
    do_exit();
  endtask

  task automatic t_rti_held();
    cyc(1, 1, 0, 0, 0);
    chk("R1 entry", ir_load_o, 1);
    cyc(0, 0, 0, 1, 0);
    chk("R8 active kept", brk_active_o, 1);
    chk("R8 no exit", brk_exit_o, 0);
    cyc(1, 1, 0, 0, 0);
    chk("R9 no reentry", ir_load_o, 0);
    do_exit();
    cyc(0, 1, 0, 0, 0);
    chk("R9 no pending after exit", ir_load_o, 0);
  endtask

  task automatic t_rti_idle();
    cyc(0, 0, 0, 1, 1);
    chk("R11 no exit idle", brk_exit_o, 0);
  endtask

  initial begin
    t_reset();
    t_last_normal();
    t_mid_monitor();
    t_rti_held();
    t_rti_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule